// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupts

This block is a register-mapped general-purpose I/O port of up to 32 pins. Software sets a pin to drive or to listen through a direction word. It places output values in a data word. It reads the synchronised pin levels back as one word. Each pin also feeds an interrupt stage. That stage can watch for a rising edge, a falling edge, a high level or a low level. The block merges every enabled pending source into a single interrupt line for the processor.

The bus is a simple single-cycle register port. A write commits at the rising clock edge on which select and write are both high. A read returns data combinationally in the cycle in which select is high and write is low. A write lands in the targeted register at that edge. It changes the outputs from the next cycle on. Pin inputs are asynchronous. Each one crosses a two-flop synchroniser before the block reads it back or uses it for interrupt detection.

Top module: `gpio_port`

## Requirements
- R1: While reset is held and right after it, every register reads 0, pin_out and pin_oe are 0 and irq is 0.
- R2: A write to offset 0x04 replaces the direction word. Bit i = 1 makes pin i an output (pin_oe[i] = 1) from the next cycle. The word reads back at 0x04.
- R3: A write to offset 0x00 replaces the whole output data word, with no merging. pin_out equals it from the next cycle, and it reads back at 0x00.
- R4: Offset 0x44 reads the pin_in levels. A level applied before clock edge k is returned from the cycle after edge k+1, after two synchroniser flops.
- R5: The interrupt registers sit from 0x30 upward: enable at 0x30, type at 0x34 and polarity at 0x38. Each reads back what was last written.
- R6: For an enabled pin with type bit 1, polarity 1 latches a rising edge and polarity 0 latches a falling edge. The edge is taken from the synchronised input against its value one cycle earlier. It shows as bit i of the status word at 0x3C.
- R7: A latched edge stays set until a write to 0x40 carries a 1 in its bit. Bits written 0 are untouched. A new edge in the same cycle as the clear leaves the bit set.
- R8: For an enabled pin with type bit 0, the status bit equals the synchronised level when polarity is 1, or its inverse when polarity is 0. It is not latched, so a clear write has no lasting effect while the level persists.
- R9: A pin whose enable bit is 0 sets no status bit and latches no edge, and it cannot raise irq.
- R10: irq is the OR of the status bits whose enable bits are 1.
- R11: Unmapped offsets and the clear register at 0x40 read as 0. A write to an unmapped offset changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (8) | Byte offset of the register |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data, valid while bus_sel=1 and bus_wr=0 |
| pin_in | input | NPIN (32) | Asynchronous pin input levels |
| pin_out | output | NPIN (32) | Output data driven towards the pads |
| pin_oe | output | NPIN (32) | Output enable per pin |
| irq | output | 1 | Combined interrupt request |

## Verification
The properties assume that bus offsets are word-aligned, and that the bus inputs are stable around each rising edge. They also assume that reset is released away from an edge. pin_in is treated as fully asynchronous, and the edge and level properties look only at its synchronised copy. The stimulus changes every bus signal and pin level just after the falling edge and uses only word-aligned offsets. It still sends edges on the same cycle as clear writes and as changes of type, polarity and enable, which is the overlap the latch priority has to settle.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_DOUT,
    SEL_DIR,
    SEL_IEN,
    SEL_ITYPE,
    SEL_IPOL,
    SEL_ISTAT,
    SEL_IEOI,
    SEL_EXT
  } reg_sel_e;

  localparam int unsigned OFFW = 16;

  localparam logic [OFFW-1:0] OFF_DOUT     = 16'h0000;
  localparam logic [OFFW-1:0] OFF_DIR      = 16'h0004;
  localparam logic [OFFW-1:0] OFF_IRQ_BASE = 16'h0030;
  localparam logic [OFFW-1:0] OFF_IEN      = OFF_IRQ_BASE + 16'h0000;
  localparam logic [OFFW-1:0] OFF_ITYPE    = OFF_IRQ_BASE + 16'h0004;
  localparam logic [OFFW-1:0] OFF_IPOL     = OFF_IRQ_BASE + 16'h0008;
  localparam logic [OFFW-1:0] OFF_ISTAT    = OFF_IRQ_BASE + 16'h000C;
  localparam logic [OFFW-1:0] OFF_IEOI     = OFF_IRQ_BASE + 16'h0010;
  localparam logic [OFFW-1:0] OFF_EXT      = OFF_IRQ_BASE + 16'h0014;

  function automatic reg_sel_e decode_off(input logic [OFFW-1:0] off);
    reg_sel_e s;
    case (off)
      OFF_DOUT:  s = SEL_DOUT;
      OFF_DIR:   s = SEL_DIR;
      OFF_IEN:   s = SEL_IEN;
      OFF_ITYPE: s = SEL_ITYPE;
      OFF_IPOL:  s = SEL_IPOL;
      OFF_ISTAT: s = SEL_ISTAT;
      OFF_IEOI:  s = SEL_IEOI;
      OFF_EXT:   s = SEL_EXT;
      default:   s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned N      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_async,
  output logic [N-1:0] q_sync
);

  logic [N-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [N-1:0] stg_d;
    if (s == 0) begin : g_first
      always_comb stg_d = d_async;
    end else begin : g_next
      always_comb stg_d = stg_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= '0;
      else        stg_q[s] <= stg_d;
    end
  end

  assign q_sync = stg_q[STAGES-1];

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned N  = 32,
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [N-1:0]  status,
  input  logic [N-1:0]  ext_lvl,
  output logic [N-1:0]  dout_q,
  output logic [N-1:0]  dir_q,
  output logic [N-1:0]  ien_q,
  output logic [N-1:0]  itype_q,
  output logic [N-1:0]  ipol_q,
  output logic [N-1:0]  eoi_clr
);

  logic [OFFW-1:0] off;
  reg_sel_e        sel;
  logic            wr_hit;
  logic            rd_hit;
  logic [N-1:0]    wval;
  logic            dout_we, dir_we, ien_we, itype_we, ipol_we;

  always_comb begin
    off      = OFFW'(bus_addr);
    sel      = decode_off(off);
    wr_hit   = bus_sel & bus_wr;
    rd_hit   = bus_sel & ~bus_wr;
    wval     = bus_wdata[N-1:0];
    dout_we  = wr_hit && (sel == SEL_DOUT);
    dir_we   = wr_hit && (sel == SEL_DIR);
    ien_we   = wr_hit && (sel == SEL_IEN);
    itype_we = wr_hit && (sel == SEL_ITYPE);
    ipol_we  = wr_hit && (sel == SEL_IPOL);
    eoi_clr  = (wr_hit && (sel == SEL_IEOI)) ? wval : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q  <= '0;
      dir_q   <= '0;
      ien_q   <= '0;
      itype_q <= '0;
      ipol_q  <= '0;
    end else begin
      if (dout_we)  dout_q  <= wval;
      if (dir_we)   dir_q   <= wval;
      if (ien_we)   ien_q   <= wval;
      if (itype_we) itype_q <= wval;
      if (ipol_we)  ipol_q  <= wval;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_hit) begin
      case (sel)
        SEL_DOUT:  bus_rdata = DW'(dout_q);
        SEL_DIR:   bus_rdata = DW'(dir_q);
        SEL_IEN:   bus_rdata = DW'(ien_q);
        SEL_ITYPE: bus_rdata = DW'(itype_q);
        SEL_IPOL:  bus_rdata = DW'(ipol_q);
        SEL_ISTAT: bus_rdata = DW'(status);
        SEL_EXT:   bus_rdata = DW'(ext_lvl);
        default:   bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/gpio_irq.sv
module gpio_irq #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  input  logic [N-1:0] ien,
  input  logic [N-1:0] itype,
  input  logic [N-1:0] ipol,
  input  logic [N-1:0] eoi_clr,
  output logic [N-1:0] status,
  output logic         irq
);

  for (genvar i = 0; i < N; i++) begin : g_pin
    logic prev_q;
    logic lat_q, lat_d, lat_en;
    logic hit, lvl_act;

    always_comb begin
      hit     = itype[i] & ien[i] &
                (ipol[i] ? (lvl[i] & ~prev_q) : (~lvl[i] & prev_q));
      lat_en  = hit | eoi_clr[i];
      lat_d   = hit | (lat_q & ~eoi_clr[i]);
      lvl_act = ~itype[i] & ien[i] & (ipol[i] ? lvl[i] : ~lvl[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q <= 1'b0;
        lat_q  <= 1'b0;
      end else begin
        prev_q <= lvl[i];
        if (lat_en) lat_q <= lat_d;
      end
    end

    assign status[i] = lat_q | lvl_act;
  end

  assign irq = |(status & ien);

endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int unsigned NPIN = 32,
  parameter int unsigned DW   = 32,
  parameter int unsigned AW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_oe,
  output logic            irq
);

  localparam int unsigned SYNC_STAGES = 2;

  logic [NPIN-1:0] in_sync;
  logic [NPIN-1:0] status;
  logic [NPIN-1:0] dout_q, dir_q, ien_q, itype_q, ipol_q;
  logic [NPIN-1:0] eoi_clr;

  gpio_sync #(.N(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (pin_in),
    .q_sync  (in_sync)
  );

  gpio_regs #(.N(NPIN), .DW(DW), .AW(AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .status    (status),
    .ext_lvl   (in_sync),
    .dout_q    (dout_q),
    .dir_q     (dir_q),
    .ien_q     (ien_q),
    .itype_q   (itype_q),
    .ipol_q    (ipol_q),
    .eoi_clr   (eoi_clr)
  );

  gpio_irq #(.N(NPIN)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .lvl     (in_sync),
    .ien     (ien_q),
    .itype   (itype_q),
    .ipol    (ipol_q),
    .eoi_clr (eoi_clr),
    .status  (status),
    .irq     (irq)
  );

  assign pin_out = dout_q;
  assign pin_oe  = dir_q;

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_pkg::*;
#(
  parameter int unsigned NPIN = 32,
  parameter int unsigned DW   = 32,
  parameter int unsigned AW   = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_sel,
  input logic            bus_wr,
  input logic [AW-1:0]   bus_addr,
  input logic [DW-1:0]   bus_wdata,
  input logic [NPIN-1:0] pin_out,
  input logic [NPIN-1:0] pin_oe,
  input logic            irq,
  input logic [NPIN-1:0] in_sync,
  input logic [NPIN-1:0] status,
  input logic [NPIN-1:0] ien_q,
  input logic [NPIN-1:0] itype_q,
  input logic [NPIN-1:0] ipol_q
);

  logic [NPIN-1:0] seen_q;
  logic [NPIN-1:0] edge_want;
  logic [NPIN-1:0] lvl_want;
  logic            wr_dir, wr_dout;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= '0;
    else        seen_q <= in_sync;
  end

  always_comb begin
    edge_want = ien_q & itype_q &
                ((ipol_q & in_sync & ~seen_q) | (~ipol_q & ~in_sync & seen_q));
    lvl_want  = ien_q & ~itype_q & ~(ipol_q ^ in_sync);
    wr_dir    = bus_sel && bus_wr && (OFFW'(bus_addr) == OFF_DIR);
    wr_dout   = bus_sel && bus_wr && (OFFW'(bus_addr) == OFF_DOUT);
  end

  // R2
  dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> (pin_oe == $past(bus_wdata[NPIN-1:0])));

  // R3
  dout_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dout |=> (pin_out == $past(bus_wdata[NPIN-1:0])));

  // R9
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq);

  // R6
  edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_want != '0) |=> ((status & $past(edge_want)) == $past(edge_want)));

  // R8
  level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status & lvl_want) == lvl_want);

endmodule

bind gpio_port gpio_port_chk #(.NPIN(NPIN), .DW(DW), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .irq       (irq),
  .in_sync   (in_sync),
  .status    (status),
  .ien_q     (ien_q),
  .itype_q   (itype_q),
  .ipol_q    (ipol_q)
);

// File: tb/gpio_port_tb.sv
module gpio_port_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = 32'h0;
  logic [31:0] pin_out, pin_oe;
  logic        irq;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 0;
  string phase = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // behavioural reference model
  logic [31:0] m_dout, m_dir, m_en, m_type, m_pol, m_lat;
  logic [31:0] m_hist[$];

  always @(posedge clk) begin
    logic [31:0] s2, pv, ev, clr;
    if (!rst_n) begin
      m_dout = 0; m_dir = 0; m_en = 0; m_type = 0; m_pol = 0; m_lat = 0;
      m_hist = {32'h0, 32'h0, 32'h0};
    end else begin
      s2  = m_hist[1];
      pv  = m_hist[2];
      ev  = m_type & m_en & ((m_pol & s2 & ~pv) | (~m_pol & ~s2 & pv));
      clr = (bus_sel && bus_wr && bus_addr == 8'h40) ? bus_wdata : 32'h0;
      m_lat = (m_lat & ~clr) | ev;
      if (bus_sel && bus_wr) begin
        case (bus_addr)
          8'h00: m_dout = bus_wdata;
          8'h04: m_dir  = bus_wdata;
          8'h30: m_en   = bus_wdata;
          8'h34: m_type = bus_wdata;
          8'h38: m_pol  = bus_wdata;
          default: ;
        endcase
      end
      m_hist.push_front(pin_in);
      void'(m_hist.pop_back());
    end
  end

  function automatic logic [31:0] m_status();
    logic [31:0] s2, lv;
    s2 = m_hist[1];
    lv = ~m_type & m_en & ((m_pol & s2) | (~m_pol & ~s2));
    return m_lat | lv;
  endfunction

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h00: return m_dout;
      8'h04: return m_dir;
      8'h30: return m_en;
      8'h34: return m_type;
      8'h38: return m_pol;
      8'h3C: return m_status();
      8'h44: return m_hist[1];
      default: return 32'h0;
    endcase
  endfunction

  function automatic string rd_tag(input logic [7:0] a);
    if (phase == "R1") return "R1";
    case (a)
      8'h00: return "R3";
      8'h04: return "R2";
      8'h30, 8'h34, 8'h38: return "R5";
      8'h3C: return phase;
      8'h44: return "R4";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    string tp, ti;
    tp = (phase == "R1") ? "R1" : "R3";
    ti = (phase == "R1") ? "R1" : "R10";
    chk(tp, pin_out, m_dout);
    chk((phase == "R1") ? "R1" : "R2", pin_oe, m_dir);
    chk(ti, {31'h0, irq}, {31'h0, |(m_status() & m_en)});
    if (bus_sel && !bus_wr) chk(rd_tag(bus_addr), bus_rdata, m_read(bus_addr));
  endtask

  task automatic tick();
    @(negedge clk);
    compare();
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    tick();
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    tick();
    bus_sel = 0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] rng;
    rng = 32'h1234_5678;
    // R1: reset state, reads during and after reset
    idle(2);
    rd(8'h00); rd(8'h04); rd(8'h30);
    @(negedge clk); rst_n = 1;
    rd(8'h34); rd(8'h38); rd(8'h3C); rd(8'h44);

    // R2 / R3: direction and full-word data replacement
    phase = "R3";
    wr(8'h04, 32'h0000_FFFF); rd(8'h04);
    wr(8'h00, 32'hA5A5_1234); rd(8'h00);
    wr(8'h00, 32'h0000_00FF); rd(8'h00);
    wr(8'h04, 32'hF0F0_0001); rd(8'h04);

    // R4: synchronised read-back latency
    phase = "R4";
    pin_in = 32'hDEAD_BEEF;
    rd(8'h44); rd(8'h44); rd(8'h44); rd(8'h44);
    pin_in = 32'h0123_4567;
    rd(8'h44); rd(8'h44); rd(8'h44);

    // R5: interrupt register read-back
    phase = "R5";
    wr(8'h30, 32'h1234_ABCD); wr(8'h34, 32'h8765_4321); wr(8'h38, 32'hFFFF_0000);
    rd(8'h30); rd(8'h34); rd(8'h38);
    wr(8'h30, 32'h0); wr(8'h34, 32'h0); wr(8'h38, 32'h0);

    // R6: pin0 rising, pin1 falling edge
    phase = "R6";
    pin_in = 32'h0000_0002; idle(4);
    wr(8'h34, 32'h3); wr(8'h38, 32'h1); wr(8'h30, 32'h3);
    rd(8'h3C);
    pin_in = 32'h0000_0001; idle(4); rd(8'h3C);
    pin_in = 32'h0000_0000; idle(4); rd(8'h3C);

    // R7: selective clear, latch persistence, clear racing an edge
    phase = "R7";
    wr(8'h40, 32'h1); rd(8'h3C); idle(3); rd(8'h3C);
    wr(8'h40, 32'h2); rd(8'h3C);
    pin_in = 32'h0000_0001; idle(2);
    wr(8'h40, 32'h1); rd(8'h3C); rd(8'h3C);
    wr(8'h40, 32'h3); rd(8'h3C);

    // R8: pin2 high level, pin3 low level
    phase = "R8";
    wr(8'h34, 32'h3); wr(8'h38, 32'h5); wr(8'h30, 32'hC);
    pin_in = 32'h0000_0004; idle(4); rd(8'h3C);
    wr(8'h40, 32'hC); rd(8'h3C); idle(2); rd(8'h3C);
    pin_in = 32'h0000_0008; idle(4); rd(8'h3C);

    // R9: disabled pins neither latch nor raise irq
    phase = "R9";
    wr(8'h30, 32'h0); wr(8'h34, 32'hF); wr(8'h38, 32'hF);
    pin_in = 32'h0000_000F; idle(4); rd(8'h3C);
    pin_in = 32'h0; idle(4); rd(8'h3C);
    wr(8'h30, 32'hF); rd(8'h3C); idle(2);

    // R11: unmapped offsets and clear register read 0, writes ignored
    phase = "R11";
    rd(8'h08); rd(8'h40); rd(8'h7C);
    wr(8'h08, 32'hFFFF_FFFF); wr(8'h2C, 32'hFFFF_FFFF);
    rd(8'h00); rd(8'h04); rd(8'h30); rd(8'h34); rd(8'h38);

    // R10: mixed traffic, irq compared every cycle
    phase = "R10";
    for (int it = 0; it < 3000; it++) begin
      rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
      case (rng[2:0])
        3'd0: wr(8'h30, rng & 32'h0000_00FF);
        3'd1: wr(8'h34, {rng[31:24], rng[7:0]} & 32'h0000_00FF);
        3'd2: wr(8'h38, rng >> 8 & 32'h0000_00FF);
        3'd3: wr(8'h40, rng >> 16);
        default: rd(8'h3C);
      endcase
      if (rng[5]) pin_in = pin_in ^ (rng >> 20 & 32'h0000_00FF);
    end
    summary();
  end

endmodule